// File: doc/BRIEF.md
# SPI Debug Command Decoder

This block sits between a byte-level SPI slave shim and the two byte FIFOs of a host debug channel. The host always drives the transfer; the shim marks each chip-select period with a start pulse and an end pulse, and hands over one received byte per slot with `rx_valid`. The first byte of each frame is a command code. The decoder either returns a four-byte FIFO status word, sends every later byte of the frame into the console-bound FIFO, answers every later slot with a byte taken from the host-bound FIFO, or pulses the flush outputs.

The reply byte for the next slot is held in `tx_byte`. It is updated only on the clock edge that accepts a received byte, or on a frame boundary, so the shim can load it into its shifter at any point before the next slot begins. Both FIFO sides use valid/ready. The SPI host cannot be stalled, so back-pressure cannot hold up the stream. A push offered while `push_ready` is low is dropped and never retried. A pop request while `pop_valid` is low takes nothing and returns zero.

Top module: `dbg_spi_cmd`

## Requirements
- R1: After reset `tx_byte` is 0x00, and `push_valid`, `pop_ready`, `flush_data` and `flush_debug` are all low.
- R2: Command 0x60 returns the 32-bit word {10'b0, con_count, pc_count} over the next four slots, most significant byte first. The counts are sampled in the cycle the command byte is received, and later count changes in the same frame do not alter the word.
- R3: Under command 0x60, every slot after the fourth status byte returns 0x00.
- R4: Under command 0x70, each later received byte raises `push_valid` for exactly that cycle, with `push_data` equal to the byte. When `push_ready` is low in that cycle the byte is discarded and not offered again. `tx_byte` stays 0x00.
- R5: Command 0x80 raises `pop_ready` in the cycle of the command byte and in the cycle of each later byte. When `pop_valid` is high, `tx_byte` takes `pop_data` at that edge, so the byte goes out in the following slot.
- R6: A pop request made while `pop_valid` is low loads 0x00 into `tx_byte`.
- R7: Command 0xFF raises `flush_data` and `flush_debug` together for exactly one cycle, beginning on the edge after the command byte. The rest of the frame returns 0x00 with no push or pop.
- R8: Any other command byte makes the rest of the frame ignored: every slot returns 0x00 and nothing is pushed, popped or flushed.
- R9: A frame start or frame end pulse in any state clears `tx_byte` to 0x00 and returns the decoder to waiting for a command byte. A byte arriving in the same cycle as the pulse is dropped.
- R10: `tx_byte` changes only on an edge where `rx_valid`, `frame_start` or `frame_end` was high.
- R11: `push_valid` and `pop_ready` are never high in the same cycle, and each is high only in a cycle where `rx_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at chip-select assert |
| frame_end | input | 1 | One-cycle pulse at chip-select deassert |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Reply byte for the next slot |
| push_valid | output | 1 | Byte offered to the console-bound FIFO |
| push_ready | input | 1 | Console-bound FIFO can accept a byte |
| push_data | output | 8 | Byte for the console-bound FIFO |
| pop_ready | output | 1 | Request for a byte from the host-bound FIFO |
| pop_valid | input | 1 | Host-bound FIFO holds a byte |
| pop_data | input | 8 | Head byte of the host-bound FIFO |
| con_count | input | 11 | Bytes waiting in the console-bound FIFO |
| pc_count | input | 11 | Bytes waiting in the host-bound FIFO |
| flush_data | output | 1 | One-cycle flush pulse for the data FIFOs |
| flush_debug | output | 1 | One-cycle flush pulse for the debug FIFOs |

## Verification
The hardest case to reach is a read stream that drains the host-bound FIFO in the middle of a frame, so that a real byte and a substitute zero fall in adjacent slots. A frame boundary landing in the middle of a status word is also hard to reach. The bench keeps its own host-bound queue and preloads a random number of bytes (sometimes none) before each random read frame of random length. This produces empty pops both at the command slot and after the queue runs dry. Directed frames cut a status read after one byte, change the counts after the command byte, and hold `push_ready` low on selected bytes of a write stream.

// File: rtl/dbg_spi_pkg.sv
package dbg_spi_pkg;
  typedef enum logic [2:0] {
    ST_CMD,
    ST_STAT,
    ST_WRITE,
    ST_READ,
    ST_SKIP
  } dec_state_t;

  localparam logic [7:0] OP_STATUS = 8'h60;
  localparam logic [7:0] OP_WRITE  = 8'h70;
  localparam logic [7:0] OP_READ   = 8'h80;
  localparam logic [7:0] OP_RESET  = 8'hFF;
endpackage

// File: rtl/dbg_cmd_fsm.sv
module dbg_cmd_fsm
  import dbg_spi_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int STAT_BYTES = 4,
  localparam int IDX_W     = $clog2(STAT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_evt,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              stat_load,
  output logic              stat_step,
  output logic [IDX_W-1:0]  stat_idx,
  output logic              do_push,
  output logic              do_pop,
  output logic              do_flush
);
  dec_state_t state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic cmd_slot, slot_ok, last_stat;

  assign slot_ok   = rx_valid && !frame_evt;
  assign cmd_slot  = slot_ok && (state_q == ST_CMD);
  assign last_stat = (idx_q == IDX_W'(STAT_BYTES));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (frame_evt) begin
      state_d = ST_CMD;
      idx_d   = '0;
    end else if (cmd_slot) begin
      unique case (rx_byte)
        OP_STATUS: begin
          state_d = ST_STAT;
          idx_d   = IDX_W'(1);
        end
        OP_WRITE: state_d = ST_WRITE;
        OP_READ:  state_d = ST_READ;
        default:  state_d = ST_SKIP;
      endcase
    end else if (slot_ok && state_q == ST_STAT) begin
      if (last_stat) state_d = ST_SKIP;
      else           idx_d   = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_CMD;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign stat_load = cmd_slot && (rx_byte == OP_STATUS);
  assign stat_step = slot_ok && (state_q == ST_STAT) && !last_stat;
  assign stat_idx  = idx_q;
  assign do_push   = slot_ok && (state_q == ST_WRITE);
  assign do_pop    = (slot_ok && state_q == ST_READ) || (cmd_slot && rx_byte == OP_READ);
  assign do_flush  = cmd_slot && (rx_byte == OP_RESET);
endmodule

// File: rtl/dbg_stat_word.sv
module dbg_stat_word #(
  parameter int BYTE_W     = 8,
  parameter int CNT_W      = 11,
  parameter int STAT_BYTES = 4,
  localparam int WORD_W    = BYTE_W * STAT_BYTES,
  localparam int IDX_W     = $clog2(STAT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [IDX_W-1:0]  idx,
  input  logic [CNT_W-1:0]  con_count,
  input  logic [CNT_W-1:0]  pc_count,
  output logic [BYTE_W-1:0] byte_out
);
  logic [WORD_W-1:0] live, held_q;
  logic [BYTE_W-1:0] lanes [STAT_BYTES];

  assign live = WORD_W'({con_count, pc_count});

  always_ff @(posedge clk) begin
    if (!rst_n)    held_q <= '0;
    else if (load) held_q <= live;
  end

  // lane k is the k-th byte sent, most significant first
  for (genvar k = 0; k < STAT_BYTES; k++) begin : g_lane
    assign lanes[k] = held_q[(STAT_BYTES-1-k)*BYTE_W +: BYTE_W];
  end

  always_comb begin
    if (load) byte_out = live[WORD_W-1 -: BYTE_W];
    else      byte_out = lanes[idx[$clog2(STAT_BYTES)-1:0]];
  end
endmodule

// File: rtl/dbg_tx_reg.sv
module dbg_tx_reg #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_evt,
  input  logic              rx_valid,
  input  logic              use_stat,
  input  logic [BYTE_W-1:0] stat_byte,
  input  logic              use_pop,
  input  logic              pop_valid,
  input  logic [BYTE_W-1:0] pop_data,
  output logic [BYTE_W-1:0] tx_byte
);
  always_ff @(posedge clk) begin
    if (!rst_n || frame_evt) tx_byte <= '0;
    else if (rx_valid) begin
      if (use_stat)                 tx_byte <= stat_byte;
      else if (use_pop && pop_valid) tx_byte <= pop_data;
      else                          tx_byte <= '0;
    end
  end
endmodule

// File: rtl/dbg_spi_cmd.sv
module dbg_spi_cmd #(
  parameter int BYTE_W     = 8,
  parameter int CNT_W      = 11,
  parameter int STAT_BYTES = 4,
  localparam int IDX_W     = $clog2(STAT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [BYTE_W-1:0] push_data,
  output logic              pop_ready,
  input  logic              pop_valid,
  input  logic [BYTE_W-1:0] pop_data,
  input  logic [CNT_W-1:0]  con_count,
  input  logic [CNT_W-1:0]  pc_count,
  output logic              flush_data,
  output logic              flush_debug
);
  logic frame_evt, stat_load, stat_step, do_push, do_pop, do_flush;
  logic [IDX_W-1:0] stat_idx;
  logic [BYTE_W-1:0] stat_byte;
  logic flush_q;

  assign frame_evt = frame_start || frame_end;

  dbg_cmd_fsm #(.BYTE_W(BYTE_W), .STAT_BYTES(STAT_BYTES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .frame_evt(frame_evt),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .stat_load(stat_load), .stat_step(stat_step), .stat_idx(stat_idx),
    .do_push(do_push), .do_pop(do_pop), .do_flush(do_flush)
  );

  dbg_stat_word #(.BYTE_W(BYTE_W), .CNT_W(CNT_W), .STAT_BYTES(STAT_BYTES)) u_stat (
    .clk(clk), .rst_n(rst_n), .load(stat_load), .idx(stat_idx),
    .con_count(con_count), .pc_count(pc_count), .byte_out(stat_byte)
  );

  dbg_tx_reg #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame_evt(frame_evt), .rx_valid(rx_valid),
    .use_stat(stat_load || stat_step), .stat_byte(stat_byte),
    .use_pop(do_pop), .pop_valid(pop_valid), .pop_data(pop_data),
    .tx_byte(tx_byte)
  );

  // the console side cannot stall the host: a refused byte is simply lost
  assign push_valid = do_push;
  assign push_data  = rx_byte;
  assign pop_ready  = do_pop;

  always_ff @(posedge clk) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= do_flush;
  end

  assign flush_data  = flush_q;
  assign flush_debug = flush_q;

  logic unused_ready;
  assign unused_ready = push_ready;
endmodule

// File: rtl/dbg_spi_cmd_chk.sv
module dbg_spi_cmd_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              frame_end,
  input logic              rx_valid,
  input logic [BYTE_W-1:0] tx_byte,
  input logic              push_valid,
  input logic              pop_ready,
  input logic              pop_valid,
  input logic              flush_data,
  input logic              flush_debug
);
  assert_frame_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start || frame_end) |=> (tx_byte == '0));

  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !frame_start && !frame_end) |=> $stable(tx_byte));

  assert_no_dual_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_valid && pop_ready));

  assert_slot_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid || pop_ready) |-> rx_valid);

  assert_empty_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ready && !pop_valid && !frame_start && !frame_end) |=> (tx_byte == '0));

  assert_flush_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_data == flush_debug);

  assert_flush_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_data |=> !flush_data);
endmodule

bind dbg_spi_cmd dbg_spi_cmd_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
  .rx_valid(rx_valid), .tx_byte(tx_byte), .push_valid(push_valid),
  .pop_ready(pop_ready), .pop_valid(pop_valid),
  .flush_data(flush_data), .flush_debug(flush_debug)
);

// File: tb/dbg_spi_cmd_bench.sv
module dbg_spi_cmd_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0, frame_end = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [7:0] tx_byte, push_data, pop_data;
  logic push_valid, push_ready, pop_ready, pop_valid, flush_data, flush_debug;
  logic [10:0] con_count = '0, pc_count = '0;

  logic [7:0] pcmem [256];
  int pc_rd = 0, pc_wr = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  assign pop_valid = (pc_wr != pc_rd);
  assign pop_data  = pcmem[pc_rd[7:0]];

  always #10 clk = ~clk;

  dbg_spi_cmd u_dbg_spi_cmd (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_byte(tx_byte),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .pop_ready(pop_ready), .pop_valid(pop_valid), .pop_data(pop_data),
    .con_count(con_count), .pc_count(pc_count),
    .flush_data(flush_data), .flush_debug(flush_debug)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat_byte(input logic [10:0] c, input logic [10:0] p, input int k);
    logic [31:0] w;
    w = {10'b0, c, p};
    return w[31 - 8*k -: 8];
  endfunction

  logic [7:0] s_tx, s_pd, s_popd;
  logic s_push, s_pushv, s_pop, s_popr, s_fl;

  task automatic slot(input logic [7:0] b, input logic pr);
    rx_byte = b; rx_valid = 1'b1; push_ready = pr;
    #1;
    s_pushv = push_valid; s_push = push_valid && push_ready; s_pd = push_data;
    s_popr = pop_ready; s_pop = pop_ready && pop_valid; s_popd = pop_data;
    @(negedge clk);
    rx_valid = 1'b0;
    s_tx = tx_byte; s_fl = flush_data && flush_debug;
    if (s_pop) pc_rd++;
  endtask

  task automatic pulse_start();
    frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
    chk(tx_byte == 8'h00, "R9 start clears tx", tx_byte, 0);
  endtask

  task automatic pulse_end();
    frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
    chk(tx_byte == 8'h00, "R9 end clears tx", tx_byte, 0);
  endtask

  task automatic fill_pc(input int n);
    for (int i = 0; i < n; i++) begin
      pcmem[pc_wr[7:0]] = 8'($urandom);
      pc_wr++;
    end
  endtask

  task automatic run_frame(input logic [7:0] op, input int len, input logic [10:0] c, input logic [10:0] p);
    logic [7:0] exp;
    logic [7:0] b;
    logic pr;
    bit ev;
    con_count = c; pc_count = p;
    pulse_start();
    ev = (pc_wr != pc_rd);
    exp = ev ? pcmem[pc_rd[7:0]] : 8'h00;
    slot(op, 1'b1);
    if (op == 8'h60)
      chk(s_tx == stat_byte(c, p, 0), "R2 status byte 0", s_tx, stat_byte(c, p, 0));
    else if (op == 8'h80) begin
      chk(s_popr, "R5 pop on command slot", s_popr, 1);
      chk(s_tx == exp, ev ? "R5 popped byte" : "R6 empty pop zero", s_tx, exp);
    end else
      chk(s_tx == 8'h00, "R8 zero after command", s_tx, 0);
    chk(!s_pushv, "R11 no push on command slot", s_pushv, 0);
    if (op == 8'hFF) chk(s_fl, "R7 flush pulse", s_fl, 1);
    else             chk(!s_fl, "R8 no flush", s_fl, 0);
    for (int k = 1; k <= len; k++) begin
      b = 8'($urandom); pr = 1'($urandom);
      ev = (pc_wr != pc_rd);
      exp = ev ? pcmem[pc_rd[7:0]] : 8'h00;
      slot(b, pr);
      case (op)
        8'h60: begin
          if (k < 4) chk(s_tx == stat_byte(c, p, k), "R2 status byte", s_tx, stat_byte(c, p, k));
          else       chk(s_tx == 8'h00, "R3 zero after status", s_tx, 0);
          chk(!s_pushv && !s_popr, "R8 no stream in status", {s_pushv, s_popr}, 0);
        end
        8'h70: begin
          chk(s_pushv && s_pd == b, "R4 byte offered", s_pd, b);
          chk(s_push == pr, "R4 accept follows ready", s_push, pr);
          chk(s_tx == 8'h00, "R4 tx zero in write", s_tx, 0);
        end
        8'h80: begin
          chk(s_popr && !s_pushv, "R5 pop each slot", s_popr, 1);
          chk(s_tx == exp, ev ? "R5 popped byte" : "R6 empty pop zero", s_tx, exp);
        end
        default: begin
          chk(s_tx == 8'h00 && !s_pushv && !s_popr && !s_fl, "R8 ignored slot",
              {s_tx, s_pushv, s_popr, s_fl}, 0);
          if (op == 8'hFF) chk(!s_fl, "R7 flush once", s_fl, 0);
        end
      endcase
    end
    pulse_end();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    push_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_byte == 0 && !push_valid && !pop_ready && !flush_data && !flush_debug,
        "R1 reset state", {tx_byte, push_valid, pop_ready, flush_data}, 0);

    // R2 capture: counts change after the command byte
    con_count = 11'h5A5; pc_count = 11'h13C;
    pulse_start();
    slot(8'h60, 1'b1);
    con_count = 11'h7FF; pc_count = 11'h7FF;
    for (int k = 1; k < 4; k++) begin
      slot(8'h00, 1'b1);
      chk(s_tx == stat_byte(11'h5A5, 11'h13C, k), "R2 captured word", s_tx,
          stat_byte(11'h5A5, 11'h13C, k));
    end
    slot(8'h00, 1'b1);
    chk(s_tx == 0, "R3 fifth slot zero", s_tx, 0);
    pulse_end();

    // R9: frame cut mid status, next frame decodes a fresh command
    run_frame(8'h60, 1, 11'h3, 11'h4);
    fill_pc(2);
    run_frame(8'h80, 4, 0, 0);

    // R4: write with ready low on selected bytes
    pulse_start();
    slot(8'h70, 1'b1);
    slot(8'hAA, 1'b0);
    chk(s_pushv && !s_push && s_pd == 8'hAA, "R4 dropped when full", s_push, 0);
    slot(8'h55, 1'b1);
    chk(s_push && s_pd == 8'h55, "R4 next byte accepted", s_pd, 8'h55);
    pulse_end();

    // R9: byte arriving with frame end is dropped
    pulse_start();
    slot(8'h70, 1'b1);
    rx_byte = 8'h11; rx_valid = 1'b1; frame_end = 1'b1; #1;
    chk(!push_valid, "R9 byte with end dropped", push_valid, 0);
    @(negedge clk); rx_valid = 1'b0; frame_end = 1'b0;
    pulse_start();
    slot(8'h80, 1'b1);
    chk(s_popr, "R9 new command after end", s_popr, 1);
    pulse_end();

    run_frame(8'hFF, 3, 0, 0);
    run_frame(8'h13, 3, 0, 0);

    for (int f = 0; f < 150; f++) begin
      int sel;
      logic [7:0] op;
      sel = $urandom_range(0, 4);
      case (sel)
        0: op = 8'h60;
        1: op = 8'h70;
        2: op = 8'h80;
        3: op = 8'hFF;
        default: begin
          op = 8'($urandom);
          if (op == 8'h60 || op == 8'h70 || op == 8'h80 || op == 8'hFF) op = 8'h01;
        end
      endcase
      if (op == 8'h80) fill_pc($urandom_range(0, 4));
      run_frame(op, $urandom_range(0, 7), 11'($urandom), 11'($urandom));
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule